// File: doc/BRIEF.md
# Multiplexed Address/Data External Memory Bus Master

This block lets a processor core reach a 64 KB data space through a narrow external bus. The low address byte and the data byte take turns on one shared 8-bit set of pins. The high address byte has its own pins. An active-high latch strobe marks the address phase. Active-low read and write strobes mark the data phase. An external transparent latch holds the low address byte while the bus is turned around for data.

The core issues one request at a time, made of an address, a direction and write data. It gets back a one-cycle completion pulse, together with read data for reads. Addresses below the on-chip memory limit go to an internal memory port, and so do all requests made while the enable input is low. Those accesses never touch the external pins. While the enable input is low, the shared and high-address pins carry the general-purpose port values. While it is high, the bus master owns them.

With the default phase lengths, an external access takes one address cycle, one turnaround cycle, two strobe cycles and one recovery cycle. An internal access completes two cycles after it is accepted.

Top module: `xbus_master`

## Requirements
- R1: After reset, ale is 0, re_n and we_n are 1, busy and rsp_done are 0, rsp_rdata is 0 and the high-address pins output 0 while enabled.
- R2: A request is internal when xm_en is 0 or req_addr is below INT_LIMIT (default 4096). In its accept cycle, int_req is 1 with int_addr, int_we and int_wdata copied from the request. rsp_done follows two cycles after acceptance, and for a read rsp_rdata is the int_rdata returned one cycle after int_req. ale, re_n and we_n do not move.
- R3: An external access starts with ADDR_CYC cycles of ale=1. During these cycles the shared pins drive req_addr[7:0] with all enables set.
- R4: After ale falls, TURN_CYC cycles pass with both strobes high. For a read, the shared pins are released (enables 0) from this turnaround cycle to the end of the access.
- R5: A read holds re_n low for STRB_CYC cycles. The shared pins are sampled on the clock edge at which re_n rises. The sampled byte appears on rsp_rdata with rsp_done=1 in the following cycle.
- R6: A write holds we_n low for STRB_CYC cycles. It drives the write data on the shared pins from turnaround through one recovery cycle after we_n rises. rsp_done=1 in that recovery cycle.
- R7: re_n and we_n are never both low, and neither is low while ale is high.
- R8: busy is 1 from the cycle after acceptance until the access ends. rsp_done is a single-cycle pulse for each accepted request. Requests presented while busy are ignored.
- R9: While xm_en is 0, ale stays 0, re_n and we_n stay 1, and the shared and high pins carry gpio_lo_* and gpio_hi_*. While xm_en is 1, the pins carry bus values.
- R10: While xm_en is 1, the high-address pins are driven (all enables 1) with the high byte of the most recent external address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xm_en | input | 1 | External bus enable |
| req_valid | input | 1 | Request present (taken only when not busy) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_done on reads |
| int_req | output | 1 | Internal memory access strobe |
| int_we | output | 1 | Internal write enable |
| int_addr | output | 16 | Internal address |
| int_wdata | output | 8 | Internal write data |
| int_rdata | input | 8 | Internal read data, one cycle after int_req |
| gpio_lo_out | input | 8 | Port value for the shared pins |
| gpio_lo_oe | input | 8 | Port enables for the shared pins |
| gpio_hi_out | input | 8 | Port value for the high pins |
| gpio_hi_oe | input | 8 | Port enables for the high pins |
| pad_ad_out | output | 8 | Shared address/data pin outputs |
| pad_ad_oe | output | 8 | Shared pin output enables |
| pad_ad_in | input | 8 | Shared pin inputs |
| pad_hi_out | output | 8 | High address pin outputs |
| pad_hi_oe | output | 8 | High address pin enables |
| ale | output | 1 | Address latch strobe, active high |
| re_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |

## Verification
The assertions assume that xm_en does not change while an access is in progress, because the pin ownership and strobe checks rely on it. They also assume that the phase-length parameters are each at least one. The stimulus only toggles xm_en between accesses, once the reference model is idle, and it keeps the default phase lengths. Held and back-to-back requests are applied freely, because the block itself filters requests that arrive while busy.

// File: rtl/xbus_pkg.sv
// Shared types for the multiplexed external bus master.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package xbus_pkg;
    typedef enum logic [2:0] {
        XS_IDLE,
        XS_INT,
        XS_ADDR,
        XS_TURN,
        XS_STRB,
        XS_HOLD
    } xbus_state_e;
endpackage

// File: rtl/xbus_route.sv
// Request router: decides whether an accepted request goes to the
// internal memory port or starts an external bus cycle.
// Assumes: requests are only taken while the sequencer is idle.
module xbus_route #(
    parameter int ADDR_W    = 16,
    parameter int INT_LIMIT = 4096
) (
    input  logic              xm_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              seq_idle,
    output logic              start_int,
    output logic              start_ext
);
    localparam logic [ADDR_W-1:0] LIMIT_V = ADDR_W'(INT_LIMIT);

    logic above_limit;
    logic take;

    // Classify the address and gate acceptance by the idle state.
    always_comb begin
        above_limit = (req_addr >= LIMIT_V);
        take        = seq_idle && req_valid;
        start_ext   = take && xm_en && above_limit;
        start_int   = take && !(xm_en && above_limit);
    end
endmodule

// File: rtl/xbus_seq.sv
// Phase sequencer: runs an internal access, or the external
// sequence of address, turnaround, strobe and recovery phases. It
// also produces the strobes, the bus byte enables and the response.
// Assumes: every phase length parameter is at least 1.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int LO_W     = 8,
    parameter int HI_W     = 8,
    parameter int ADDR_CYC = 1,
    parameter int TURN_CYC = 1,
    parameter int STRB_CYC = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_int,
    input  logic                   start_ext,
    input  logic                   req_write,
    input  logic [LO_W+HI_W-1:0]   req_addr,
    input  logic [LO_W-1:0]        req_wdata,
    input  logic [LO_W-1:0]        int_rdata,
    input  logic [LO_W-1:0]        ad_in,
    output logic                   seq_idle,
    output logic                   busy,
    output logic                   ale,
    output logic                   re_n,
    output logic                   we_n,
    output logic                   bus_oe,
    output logic [LO_W-1:0]        bus_lo,
    output logic [HI_W-1:0]        bus_hi,
    output logic                   done,
    output logic [LO_W-1:0]        rdata
);
    localparam int ADDR_W = LO_W + HI_W;
    localparam int MAX_AT = (ADDR_CYC > TURN_CYC) ? ADDR_CYC : TURN_CYC;
    localparam int MAX_C  = (MAX_AT > STRB_CYC) ? MAX_AT : STRB_CYC;
    localparam int CNT_W  = (MAX_C > 1) ? $clog2(MAX_C) : 1;
    localparam logic [CNT_W-1:0] A_LD = CNT_W'(ADDR_CYC - 1);
    localparam logic [CNT_W-1:0] T_LD = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] S_LD = CNT_W'(STRB_CYC - 1);

    xbus_state_e       state;
    logic [CNT_W-1:0]  cnt;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LO_W-1:0]   wd_q;
    logic              last_strb;

    // Phase state and per-phase countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= XS_IDLE;
            cnt    <= '0;
            wr_q   <= 1'b0;
            addr_q <= '0;
            wd_q   <= '0;
        end else begin
            case (state)
                XS_IDLE: begin
                    if (start_ext) begin
                        state  <= XS_ADDR;
                        cnt    <= A_LD;
                        wr_q   <= req_write;
                        addr_q <= req_addr;
                        wd_q   <= req_wdata;
                    end else if (start_int) begin
                        state <= XS_INT;
                        wr_q  <= req_write;
                    end
                end
                XS_INT:  state <= XS_IDLE;
                XS_ADDR: begin
                    if (cnt == '0) begin
                        state <= XS_TURN;
                        cnt   <= T_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                XS_TURN: begin
                    if (cnt == '0) begin
                        state <= XS_STRB;
                        cnt   <= S_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                XS_STRB: begin
                    if (cnt == '0) begin
                        state <= XS_HOLD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                XS_HOLD: state <= XS_IDLE;
                default: state <= XS_IDLE;
            endcase
        end
    end

    // Flag the final strobe cycle, the one whose closing edge samples.
    always_comb begin
        last_strb = (state == XS_STRB) && (cnt == '0);
    end

    // Completion pulse and read data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= (state == XS_INT) || last_strb;
            if ((state == XS_INT) && !wr_q) begin
                rdata <= int_rdata;
            end else if (last_strb && !wr_q) begin
                rdata <= ad_in;
            end
        end
    end

    // Bus-level strobes and shared-byte drive decoded from the phase.
    always_comb begin
        seq_idle = (state == XS_IDLE);
        busy     = (state != XS_IDLE);
        ale      = (state == XS_ADDR);
        re_n     = !((state == XS_STRB) && !wr_q);
        we_n     = !((state == XS_STRB) && wr_q);
        bus_oe   = (state == XS_ADDR) ||
                   (wr_q && ((state == XS_TURN) || (state == XS_STRB) ||
                             (state == XS_HOLD)));
        bus_lo   = (state == XS_ADDR) ? addr_q[LO_W-1:0] : wd_q;
        bus_hi   = addr_q[ADDR_W-1:LO_W];
    end
endmodule

// File: rtl/xbus_pinmux.sv
// Pin ownership multiplexer: each pin takes either the bus value or
// the general-purpose port value, according to the enable.
// Assumes: bus_oe applies to every bit of the group at once.
module xbus_pinmux #(
    parameter int W = 8
) (
    input  logic         bus_en,
    input  logic [W-1:0] bus_out,
    input  logic         bus_oe,
    input  logic [W-1:0] gpio_out,
    input  logic [W-1:0] gpio_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        // Per-pin owner selection.
        always_comb begin
            pad_out[i] = bus_en ? bus_out[i] : gpio_out[i];
            pad_oe[i]  = bus_en ? bus_oe     : gpio_oe[i];
        end
    end
endmodule

// File: rtl/xbus_master.sv
// Top level of the multiplexed address/data external memory master.
// Connects router, sequencer and the two pin groups.
// Assumes: xm_en is held steady while busy is high.
module xbus_master #(
    parameter int LO_W      = 8,
    parameter int HI_W      = 8,
    parameter int INT_LIMIT = 4096,
    parameter int ADDR_CYC  = 1,
    parameter int TURN_CYC  = 1,
    parameter int STRB_CYC  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xm_en,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [LO_W+HI_W-1:0] req_addr,
    input  logic [LO_W-1:0]      req_wdata,
    output logic                 busy,
    output logic                 rsp_done,
    output logic [LO_W-1:0]      rsp_rdata,
    output logic                 int_req,
    output logic                 int_we,
    output logic [LO_W+HI_W-1:0] int_addr,
    output logic [LO_W-1:0]      int_wdata,
    input  logic [LO_W-1:0]      int_rdata,
    input  logic [LO_W-1:0]      gpio_lo_out,
    input  logic [LO_W-1:0]      gpio_lo_oe,
    input  logic [HI_W-1:0]      gpio_hi_out,
    input  logic [HI_W-1:0]      gpio_hi_oe,
    output logic [LO_W-1:0]      pad_ad_out,
    output logic [LO_W-1:0]      pad_ad_oe,
    input  logic [LO_W-1:0]      pad_ad_in,
    output logic [HI_W-1:0]      pad_hi_out,
    output logic [HI_W-1:0]      pad_hi_oe,
    output logic                 ale,
    output logic                 re_n,
    output logic                 we_n
);
    localparam int ADDR_W = LO_W + HI_W;

    logic            seq_idle;
    logic            start_int;
    logic            start_ext;
    logic            bus_oe;
    logic [LO_W-1:0] bus_lo;
    logic [HI_W-1:0] bus_hi;

    xbus_route #(.ADDR_W(ADDR_W), .INT_LIMIT(INT_LIMIT)) u_route (
        .xm_en     (xm_en),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .seq_idle  (seq_idle),
        .start_int (start_int),
        .start_ext (start_ext)
    );

    xbus_seq #(
        .LO_W(LO_W), .HI_W(HI_W),
        .ADDR_CYC(ADDR_CYC), .TURN_CYC(TURN_CYC), .STRB_CYC(STRB_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_int (start_int),
        .start_ext (start_ext),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .int_rdata (int_rdata),
        .ad_in     (pad_ad_in),
        .seq_idle  (seq_idle),
        .busy      (busy),
        .ale       (ale),
        .re_n      (re_n),
        .we_n      (we_n),
        .bus_oe    (bus_oe),
        .bus_lo    (bus_lo),
        .bus_hi    (bus_hi),
        .done      (rsp_done),
        .rdata     (rsp_rdata)
    );

    // Internal port carries the request straight through on acceptance.
    always_comb begin
        int_req   = start_int;
        int_we    = req_write;
        int_addr  = req_addr;
        int_wdata = req_wdata;
    end

    xbus_pinmux #(.W(LO_W)) u_mux_lo (
        .bus_en   (xm_en),
        .bus_out  (bus_lo),
        .bus_oe   (bus_oe),
        .gpio_out (gpio_lo_out),
        .gpio_oe  (gpio_lo_oe),
        .pad_out  (pad_ad_out),
        .pad_oe   (pad_ad_oe)
    );

    xbus_pinmux #(.W(HI_W)) u_mux_hi (
        .bus_en   (xm_en),
        .bus_out  (bus_hi),
        .bus_oe   (1'b1),
        .gpio_out (gpio_hi_out),
        .gpio_oe  (gpio_hi_oe),
        .pad_out  (pad_hi_out),
        .pad_oe   (pad_hi_oe)
    );
endmodule

// File: rtl/xbus_master_chk.sv
// Protocol checker for xbus_master, attached by bind.
// Assumes: xm_en is stable during an access, all phase lengths >= 1.
module xbus_master_chk #(
    parameter int LO_W      = 8,
    parameter int HI_W      = 8,
    parameter int INT_LIMIT = 4096
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 xm_en,
    input logic [LO_W+HI_W-1:0] req_addr,
    input logic                 int_req,
    input logic                 busy,
    input logic                 rsp_done,
    input logic [LO_W-1:0]      pad_ad_oe,
    input logic [HI_W-1:0]      pad_hi_oe,
    input logic                 ale,
    input logic                 re_n,
    input logic                 we_n
);
    localparam logic [LO_W+HI_W-1:0] LIMIT_V = (LO_W+HI_W)'(INT_LIMIT);

    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!re_n && !we_n));
    a_r7_no_strobe_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (re_n && we_n));
    a_r4_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (re_n && we_n));
    a_r4_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> (pad_ad_oe == '0));
    a_r6_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (&pad_ad_oe));
    a_r3_addr_driven: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (&pad_ad_oe));
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !xm_en |-> (!ale && re_n && we_n));
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r8_no_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !int_req);
    a_r2_int_route: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (!xm_en || (req_addr < LIMIT_V)));
    a_r10_hi_driven: assert property (@(posedge clk) disable iff (!rst_n)
        xm_en |-> (&pad_hi_oe));
endmodule

bind xbus_master xbus_master_chk #(
    .LO_W(LO_W), .HI_W(HI_W), .INT_LIMIT(INT_LIMIT)
) u_chk (.*);

// File: tb/xbus_master_tb.sv
// Self-checking bench with a behavioural cycle model of the bus master.
module xbus_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int A = 1;
    localparam int T = 1;
    localparam int S = 2;
    localparam int LIMIT = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xm_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, rsp_done, int_req, int_we;
    logic [7:0]  rsp_rdata, int_wdata;
    logic [15:0] int_addr;
    logic [7:0]  int_rdata = '0;
    logic [7:0]  gpio_lo_out = '0, gpio_lo_oe = '0;
    logic [7:0]  gpio_hi_out = '0, gpio_hi_oe = '0;
    logic [7:0]  pad_ad_out, pad_ad_oe, pad_ad_in, pad_hi_out, pad_hi_oe;
    logic        ale, re_n, we_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_master u_dut (
        .clk(clk), .rst_n(rst_n), .xm_en(xm_en), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .int_req(int_req), .int_we(int_we), .int_addr(int_addr),
        .int_wdata(int_wdata), .int_rdata(int_rdata),
        .gpio_lo_out(gpio_lo_out), .gpio_lo_oe(gpio_lo_oe),
        .gpio_hi_out(gpio_hi_out), .gpio_hi_oe(gpio_hi_oe),
        .pad_ad_out(pad_ad_out), .pad_ad_oe(pad_ad_oe), .pad_ad_in(pad_ad_in),
        .pad_hi_out(pad_hi_out), .pad_hi_oe(pad_hi_oe),
        .ale(ale), .re_n(re_n), .we_n(we_n)
    );

    // Device models: internal RAM, external latch and external RAM.
    logic [7:0]  int_mem [256];
    logic [7:0]  ext_mem [1024];
    logic [7:0]  sh_int  [256];
    logic [7:0]  sh_ext  [1024];
    logic [7:0]  lat = '0;
    logic [15:0] xa;

    always @(posedge clk) if (int_req) begin
        if (int_we) int_mem[int_addr[7:0]] <= int_wdata;
        int_rdata <= int_mem[int_addr[7:0]];
    end
    always @* if (ale === 1'b1) lat = pad_ad_out;
    assign xa = {pad_hi_out, lat};
    assign pad_ad_in = (re_n === 1'b0) ? ext_mem[xa[9:0]] : 8'h00;
    always @(posedge we_n) if (rst_n === 1'b1) ext_mem[xa[9:0]] = pad_ad_out;

    // Reference model state.
    int          m_mode = 0, m_t = 0;
    logic        m_we = 0, m_done = 0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_wd = '0, m_rdata = '0, m_hi = '0;
    int          vec = 0, miss = 0, cyc = 0, gp = 0;
    bit          in_reset = 1'b1;

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vec, miss);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            miss++;
            $display("FAIL R8 watchdog act=%0d exp=<100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string rq, input string nm,
                       input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s %s act=%h exp=%h", rq, nm, act, exp);
        end
    endtask

    // Compare every output with the model after the clock has settled.
    task automatic compare();
        logic       ext, drv;
        logic [7:0] exp_lo;
        string      r;
        ext = (m_mode == 2);
        r = in_reset ? "R1" : "R3";
        chk(r, "ale", ale, ext && m_t <= A);
        r = in_reset ? "R1" : "R5";
        chk(r, "re_n", re_n, !(ext && !m_we && m_t > A+T && m_t <= A+T+S));
        r = in_reset ? "R1" : "R6";
        chk(r, "we_n", we_n, !(ext && m_we && m_t > A+T && m_t <= A+T+S));
        r = in_reset ? "R1" : "R8";
        chk(r, "busy", busy, m_mode != 0);
        chk(r, "rsp_done", rsp_done, m_done);
        r = in_reset ? "R1" : "R5";
        chk(r, "rsp_rdata", rsp_rdata, m_rdata);
        if (xm_en) begin
            drv = ext && (m_t <= A || (m_we && m_t <= A+T+S+1));
            exp_lo = (m_t <= A) ? m_addr[7:0] : m_wd;
            chk("R4", "pad_ad_oe", pad_ad_oe, {8{drv}});
            if (drv) chk("R6", "pad_ad_out", pad_ad_out, exp_lo);
            r = in_reset ? "R1" : "R10";
            chk(r, "pad_hi_oe", pad_hi_oe, 8'hFF);
            chk(r, "pad_hi_out", pad_hi_out, m_hi);
        end else begin
            chk("R9", "pad_ad_oe", pad_ad_oe, gpio_lo_oe);
            chk("R9", "pad_ad_out", pad_ad_out, gpio_lo_out);
            chk("R9", "pad_hi_oe", pad_hi_oe, gpio_hi_oe);
            chk("R9", "pad_hi_out", pad_hi_out, gpio_hi_out);
        end
    endtask

    // One clock: check the internal port, advance the model, compare.
    task automatic tick();
        int          n_mode, n_t;
        logic        n_we, n_done, internal;
        logic [15:0] n_addr;
        logic [7:0]  n_wd, n_rdata, n_hi;
        gp++;
        gpio_lo_out = 8'(gp * 37);
        gpio_lo_oe  = 8'(gp * 11);
        gpio_hi_out = 8'(gp * 53);
        gpio_hi_oe  = 8'(gp * 5);
        #1;
        internal = !xm_en || (req_addr < 16'(LIMIT));
        if (rst_n) begin
            chk("R2", "int_req", int_req, m_mode == 0 && req_valid && internal);
            if (int_req) begin
                chk("R2", "int_addr", int_addr, req_addr);
                chk("R2", "int_we", int_we, req_write);
                chk("R2", "int_wdata", int_wdata, req_wdata);
            end
        end
        n_mode = m_mode; n_t = m_t; n_we = m_we; n_addr = m_addr;
        n_wd = m_wd; n_rdata = m_rdata; n_hi = m_hi; n_done = 1'b0;
        if (!rst_n) begin
            n_mode = 0; n_t = 0; n_rdata = '0; n_hi = '0;
        end else if (m_mode == 1) begin
            n_done = 1'b1;
            if (!m_we) n_rdata = sh_int[m_addr[7:0]];
            n_mode = 0;
        end else if (m_mode == 2) begin
            if (m_t == A+T+S) begin
                n_done = 1'b1;
                if (!m_we) n_rdata = sh_ext[m_addr[9:0]];
            end
            if (m_t == A+T+S+1) n_mode = 0;
            else n_t = m_t + 1;
        end else if (req_valid) begin
            n_we = req_write; n_addr = req_addr; n_wd = req_wdata; n_t = 1;
            if (internal) begin
                n_mode = 1;
                if (req_write) sh_int[req_addr[7:0]] = req_wdata;
            end else begin
                n_mode = 2;
                n_hi = req_addr[15:8];
                if (req_write) sh_ext[req_addr[9:0]] = req_wdata;
            end
        end
        @(negedge clk);
        m_mode = n_mode; m_t = n_t; m_we = n_we; m_addr = n_addr;
        m_wd = n_wd; m_rdata = n_rdata; m_hi = n_hi; m_done = n_done;
        compare();
    endtask

    task automatic issue(input logic wr, input logic [15:0] ad,
                         input logic [7:0] wd);
        req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = wd;
        tick();
        req_valid = 1'b0;
        while (m_mode != 0) tick();
        tick();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            int_mem[i] = 8'(i ^ 8'h5A);
            sh_int[i]  = 8'(i ^ 8'h5A);
        end
        for (int i = 0; i < 1024; i++) begin
            ext_mem[i] = 8'(i * 7 + 3);
            sh_ext[i]  = 8'(i * 7 + 3);
        end
        xm_en = 1'b1;
        @(negedge clk);
        // R1: reset state observed while reset is held
        tick();
        tick();
        rst_n = 1'b1;
        in_reset = 1'b0;
        tick();
        // R3 R5 R6: external write then read back, and a fresh read
        issue(1'b1, 16'h1234, 8'hA5);
        issue(1'b0, 16'h1234, 8'h00);
        issue(1'b0, 16'h2345, 8'h00);
        // R2: internal accesses up to the limit, external at the limit
        issue(1'b1, 16'h0FFF, 8'h3C);
        issue(1'b0, 16'h0FFF, 8'h00);
        issue(1'b1, 16'h1000, 8'h77);
        issue(1'b0, 16'h1000, 8'h00);
        issue(1'b0, 16'h0000, 8'h00);
        // R8: requests held across busy cycles, back to back
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h8055; req_wdata = 8'h11;
        for (int i = 0; i < 13; i++) tick();
        req_write = 1'b0; req_addr = 16'hA055;
        for (int i = 0; i < 13; i++) tick();
        req_addr = 16'h0042;
        for (int i = 0; i < 7; i++) tick();
        req_valid = 1'b0;
        while (m_mode != 0) tick();
        tick();
        // R9: disabled, high addresses go internal and pins carry port values
        xm_en = 1'b0;
        tick();
        issue(1'b1, 16'hF00F, 8'h99);
        issue(1'b0, 16'hF00F, 8'h00);
        for (int i = 0; i < 6; i++) tick();
        // R10: re-enabled, the external location was left untouched
        xm_en = 1'b1;
        tick();
        issue(1'b0, 16'hF00F, 8'h00);
        issue(1'b1, 16'h0010, 8'h5E);
        for (int i = 0; i < 3; i++) tick();
        summary();
        $finish;
    end
endmodule